// File: doc/BRIEF.md
# Two-Field Feedback and Reference Divider for a Frequency Synthesizer

This block divides the oscillator clock of a synthesizer loop. It sends one feedback pulse to the phase detector at the end of every divide period. The feedback ratio M comes from a 12-bit count field N and a 4-bit auxiliary field A. With A at zero the ratio is twice N. With A nonzero the ratio gains A plus one extra cycle, so odd ratios can be reached. A second, 7-bit divider sets the reference pre-divide ratio D. A D of zero is the code that powers the path down.

All three fields are sampled together, and only when the load strobe is high. A new ratio is taken up at the next period boundary of the divider it belongs to, so no period is ever cut short or stretched. A setting whose N and A break the legality rule raises a flag, and the feedback divider keeps running at the last legal ratio.

Each divider is the same three-state machine:
- IDLE: the powered-down state.
- COUNT: the cycles of a period before its last one.
- FIRE: the last cycle of a period, in which the output is high.

The transitions are:
- IDLE→COUNT when the path is enabled.
- COUNT→FIRE when the count reaches the ratio minus two.
- FIRE→COUNT to start the next period.
- FIRE→FIRE when the ratio being taken up is one.
- COUNT→IDLE and FIRE→IDLE when power-down is entered.

The ratio is loaded in FIRE and in IDLE only.

Top module: `pll_fb_divider`

## Requirements
- R1: With A = 0, the feedback output pulses every 2·N clock cycles.
- R2: With A > 0, the feedback output pulses every 2·N + A + 1 clock cycles.
- R3: `cfg_illegal` is high, from the cycle after the load, exactly when the loaded setting has N < 2, or A ≥ N − 1, or a resulting ratio below 10. A legal setting clears it.
- R4: While `cfg_illegal` is high, the feedback period stays at the last legal ratio.
- R5: N, A and D are captured only in a cycle with `cfg_load` high. Field changes without the strobe have no effect on either period.
- R6: The feedback period that is in progress when a load occurs completes with its old length. The new ratio applies from the following period.
- R7: Each feedback pulse is exactly one cycle wide.
- R8: For D in 1..127, the reference output pulses every D cycles. With D = 1 it is high in every cycle.
- R9: Loading D = 0 raises `pwr_down` from the next cycle and holds both outputs low. Loading a nonzero D afterwards restarts both dividers at the start of a period: the feedback pulse comes after M cycles and the reference pulse after D cycles.
- R10: Synchronous active-high reset restores N = 5, A = 0, D = 4 and holds both outputs low. After release, the first feedback pulse is in the 10th cycle and the first reference pulse is in the 4th cycle.
- R11: The largest setting, N = 4095 with A = 15, is legal and gives a period of 8206 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe that captures N, A and D |
| cfg_n | input | 12 | Feedback count field N |
| cfg_a | input | 4 | Auxiliary field A |
| cfg_d | input | 7 | Reference ratio D (0 = power-down) |
| fb_pulse | output | 1 | One-cycle pulse at the end of each feedback period |
| ref_pulse | output | 1 | One-cycle pulse at the end of each reference period |
| cfg_illegal | output | 1 | Loaded N/A setting breaks the legality rule |
| pwr_down | output | 1 | Path is powered down (D = 0) |

## Verification
A wrong count, state or latched ratio inside either machine shows up as a pulse interval that is off by one or more cycles. That error appears no later than the first full period after the fault. For this reason every interval is measured in exact clock edges, and each is measured against the period in progress at the load as well as the one after it. A ratio taken up too early or too late is therefore seen within a single period. A machine that stays in FIRE appears in the very next cycle as a pulse two cycles wide. A legality decode that is wrong appears in the flag one cycle after the load, and in the period that follows it.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // phase of one period-divider machine
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_FIRE  = 2'd2
    } phase_t;

endpackage

// File: rtl/pdiv_ratio_calc.sv
module pdiv_ratio_calc #(
    parameter int NW        = 12,
    parameter int AW        = 4,
    parameter int MIN_RATIO = 10,
    localparam int RW       = NW + 2
) (
    input  logic [NW-1:0] n_val,
    input  logic [AW-1:0] a_val,
    output logic [RW-1:0] ratio,
    output logic          legal
);

    logic [RW-1:0] twice_n;
    logic [NW:0]   a_plus_one;
    logic          shape_ok;

    always_comb begin
        twice_n = {1'b0, n_val, 1'b0};
        if (a_val == '0) begin
            ratio = twice_n;
        end else begin
            ratio = twice_n + RW'(a_val) + RW'(1);
        end
        // A < N - 1 written without a subtraction that could wrap
        a_plus_one = (NW+1)'(a_val) + (NW+1)'(1);
        shape_ok   = (n_val >= NW'(2)) && (a_plus_one < {1'b0, n_val});
        legal      = shape_ok && (ratio >= RW'(MIN_RATIO));
    end

endmodule

// File: rtl/pdiv_period_fsm.sv
module pdiv_period_fsm
    import pdiv_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] init_len,
    input  logic [CW-1:0] next_len,
    input  logic          next_ok,
    output logic          pulse
);

    phase_t        state_q;
    phase_t        state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] eff_len;
    logic          last_cnt;

    always_comb begin
        eff_len  = next_ok ? next_len : len_q;
        last_cnt = ({1'b0, cnt_q} + (CW+1)'(2)) >= {1'b0, len_q};
        state_d  = state_q;
        unique case (state_q)
            PH_IDLE:  state_d = run ? PH_COUNT : PH_IDLE;
            PH_COUNT: begin
                if (!run)          state_d = PH_IDLE;
                else if (last_cnt) state_d = PH_FIRE;
                else               state_d = PH_COUNT;
            end
            PH_FIRE: begin
                if (!run)                   state_d = PH_IDLE;
                else if (eff_len == CW'(1)) state_d = PH_FIRE;
                else                        state_d = PH_COUNT;
            end
            default:  state_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_COUNT;
        else     state_q <= state_d;
    end

    // count and latched ratio; the ratio changes only at a boundary or while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= init_len;
        end else begin
            if (state_q == PH_COUNT && state_d == PH_COUNT) cnt_q <= cnt_q + CW'(1);
            else                                            cnt_q <= '0;
            if ((state_q == PH_FIRE || state_q == PH_IDLE) && next_ok) len_q <= next_len;
        end
    end

    // output process
    always_comb begin
        pulse = (state_q == PH_FIRE) && run;
    end

    p_len_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_COUNT) |=> $stable(len_q));

    p_one_wide_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_FIRE) |=> (state_q != PH_FIRE) || (len_q == CW'(1)));

    p_cnt_inside_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_COUNT && len_q >= CW'(2)) |-> ({1'b0, cnt_q} + (CW+1)'(2)) <= {1'b0, len_q});

    p_idle_follows_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (state_q == PH_IDLE));

endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider #(
    parameter int NW        = 12,
    parameter int AW        = 4,
    parameter int DW        = 7,
    parameter int MIN_RATIO = 10,
    parameter int RST_N     = 5,
    parameter int RST_A     = 0,
    parameter int RST_D     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [11:0]   cfg_n,
    input  logic [3:0]    cfg_a,
    input  logic [6:0]    cfg_d,
    output logic          fb_pulse,
    output logic          ref_pulse,
    output logic          cfg_illegal,
    output logic          pwr_down
);

    localparam int RW    = NW + 2;
    localparam int RST_M = (RST_A == 0) ? 2 * RST_N : 2 * RST_N + RST_A + 1;

    logic [NW-1:0] n_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic [RW-1:0] fb_ratio;
    logic          fb_legal;
    logic          path_on;

    // configuration capture, strobe only
    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= NW'(RST_N);
            a_q <= AW'(RST_A);
            d_q <= DW'(RST_D);
        end else if (cfg_load) begin
            n_q <= cfg_n;
            a_q <= cfg_a;
            d_q <= cfg_d;
        end
    end

    pdiv_ratio_calc #(
        .NW        (NW),
        .AW        (AW),
        .MIN_RATIO (MIN_RATIO)
    ) u_calc (
        .n_val (n_q),
        .a_val (a_q),
        .ratio (fb_ratio),
        .legal (fb_legal)
    );

    always_comb begin
        path_on     = (d_q != '0);
        pwr_down    = !path_on;
        cfg_illegal = !fb_legal;
    end

    pdiv_period_fsm #(.CW(RW)) u_fb (
        .clk      (clk),
        .rst      (rst),
        .run      (path_on),
        .init_len (RW'(RST_M)),
        .next_len (fb_ratio),
        .next_ok  (fb_legal),
        .pulse    (fb_pulse)
    );

    pdiv_period_fsm #(.CW(DW)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .run      (path_on),
        .init_len (DW'(RST_D)),
        .next_len (d_q),
        .next_ok  (path_on),
        .pulse    (ref_pulse)
    );

    p_capture_only_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> ($stable(n_q) && $stable(a_q) && $stable(d_q)));

    p_keep_legal_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_illegal |=> $stable(u_fb.len_q));

    p_pd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!fb_pulse && !ref_pulse));

    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!fb_pulse && !ref_pulse));

endmodule

// File: tb/pll_fb_divider_bench.sv
module pll_fb_divider_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [11:0] cfg_n = '0;
    logic [3:0]  cfg_a = '0;
    logic [6:0]  cfg_d = '0;
    logic        fb_pulse, ref_pulse, cfg_illegal, pwr_down;

    int n_checks = 0;
    int n_fails  = 0;
    int cur_m    = 10;

    always #5 clk = ~clk;

    pll_fb_divider u_pll_fb_divider (
        .clk         (clk),
        .rst         (rst),
        .cfg_load    (cfg_load),
        .cfg_n       (cfg_n),
        .cfg_a       (cfg_a),
        .cfg_d       (cfg_d),
        .fb_pulse    (fb_pulse),
        .ref_pulse   (ref_pulse),
        .cfg_illegal (cfg_illegal),
        .pwr_down    (pwr_down)
    );

    function automatic int exp_ratio(int n, int a);
        return (a == 0) ? 2 * n : 2 * n + a + 1;
    endfunction

    function automatic bit exp_legal(int n, int a);
        return (n >= 2) && (a < n - 1) && (exp_ratio(n, a) >= 10);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic next_fb(output int e);
        e = 0;
        do begin
            @(posedge clk); #1; e++;
        end while (!fb_pulse && e < 20000);
    endtask

    task automatic next_ref(output int e);
        e = 0;
        do begin
            @(posedge clk); #1; e++;
        end while (!ref_pulse && e < 20000);
    endtask

    task automatic load(int n, int a, int d);
        @(negedge clk);
        cfg_n = 12'(n); cfg_a = 4'(a); cfg_d = 7'(d); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_n = 12'($urandom); cfg_a = 4'($urandom); cfg_d = 7'($urandom);
    endtask

    task automatic apply(int n, int a, int d, string tag);
        int e, e2, e3;
        bit lg;
        int oldm;
        lg   = exp_legal(n, a);
        oldm = cur_m;
        next_fb(e);
        repeat (2) @(posedge clk);
        load(n, a, d);
        chk(cfg_illegal == !lg, "R3 legality flag", int'(cfg_illegal), int'(!lg));
        next_fb(e2);
        chk(e2 + 3 == oldm, "R6 period in progress keeps old length", e2 + 3, oldm);
        @(posedge clk); #1;
        chk(fb_pulse == 1'b0, "R7 pulse one cycle wide", int'(fb_pulse), 0);
        if (lg) cur_m = exp_ratio(n, a);
        next_fb(e3);
        chk(e3 + 1 == cur_m, tag, e3 + 1, cur_m);
        next_ref(e);
        next_ref(e);
        chk(e == d, "R8 reference period", e, d);
    endtask

    task automatic reset_check();
        int first_fb, first_ref, e;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!fb_pulse && !ref_pulse, "R10 outputs low in reset", int'(fb_pulse | ref_pulse), 0);
        chk(!pwr_down && !cfg_illegal, "R10 flags clear in reset", int'(pwr_down | cfg_illegal), 0);
        rst = 1'b0;
        first_fb = 0; first_ref = 0;
        for (int i = 1; i <= 12; i++) begin
            @(posedge clk); #1;
            if (fb_pulse && first_fb == 0) first_fb = i;
            if (ref_pulse && first_ref == 0) first_ref = i;
        end
        chk(first_fb == 9, "R10 first feedback pulse in 10th cycle", first_fb, 9);
        chk(first_ref == 3, "R10 first reference pulse in 4th cycle", first_ref, 3);
        cur_m = 10;
        next_fb(e);
        next_fb(e);
        chk(e == 10, "R10 default ratio restored", e, 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int e;
        void'($urandom(32'd2024));
        reset_check();

        apply(7, 0, 5, "R1 even ratio");
        apply(6, 3, 3, "R2 odd ratio");
        apply(4, 3, 6, "R4 illegal A equals N-1 keeps ratio");
        apply(3, 1, 6, "R4 illegal ratio below 10 keeps ratio");
        apply(1, 0, 9, "R4 illegal N of one keeps ratio");
        apply(4, 1, 9, "R2 minimum legal ratio 10");
        apply(5, 4, 2, "R4 illegal A equals N-1 keeps ratio");
        apply(9, 2, 127, "R2 odd ratio with largest D");

        for (int i = 0; i < 12; i++) begin
            int n, a, d;
            n = 2 + int'($urandom % 100);
            a = int'($urandom % 16);
            d = 1 + int'($urandom % 40);
            apply(n, a, d, !exp_legal(n, a) ? "R4 random illegal" :
                           (a == 0) ? "R1 random" : "R2 random");
        end

        // R8: D of one keeps the reference output high
        apply(8, 0, 1, "R1 ratio with D of one");
        @(posedge clk); #1;
        chk(ref_pulse == 1'b1, "R8 D of one high every cycle", int'(ref_pulse), 1);
        @(posedge clk); #1;
        chk(ref_pulse == 1'b1, "R8 D of one high every cycle", int'(ref_pulse), 1);

        // R5: field changes without the strobe
        @(negedge clk);
        cfg_n = 12'd40; cfg_a = 4'd7; cfg_d = 7'd3;
        next_fb(e);
        next_fb(e);
        chk(e == cur_m, "R5 no strobe keeps feedback period", e, cur_m);
        chk(cfg_illegal == 1'b0, "R5 no strobe keeps flag", int'(cfg_illegal), 0);

        // R11: largest ratio
        apply(4095, 15, 11, "R11 largest ratio 8206");
        apply(10, 0, 6, "R1 back from largest ratio");

        // R9: power-down and restart
        load(10, 0, 0);
        chk(pwr_down == 1'b1, "R9 pwr_down raised", int'(pwr_down), 1);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(posedge clk); #1;
                if (fb_pulse || ref_pulse) seen++;
            end
            chk(seen == 0, "R9 outputs low in power-down", seen, 0);
        end
        load(10, 0, 6);
        chk(pwr_down == 1'b0, "R9 pwr_down cleared", int'(pwr_down), 1'b0);
        next_fb(e);
        chk(e == 20, "R9 feedback restarts a full period", e, 20);
        load(10, 0, 0);
        repeat (5) @(posedge clk);
        load(10, 0, 6);
        next_ref(e);
        chk(e == 6, "R9 reference restarts a full period", e, 6);

        // R10: reset in the middle of operation
        apply(12, 5, 17, "R2 before second reset");
        reset_check();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule